// File: doc/BRIEF.md
# Four-Phase Instruction Cycle Sequencer

This block divides the oscillator clock into instruction cycles of four phases each. The phases run in a fixed order: Q1 for decode, Q2 for the operand read, Q3 for processing and Q4 for the write-back. It drives one strobe per phase, and the datapath uses these strobes to time its steps. It also drives a cycle enable during the final phase, when the next instruction is latched.

When a skip is taken or the program counter is changed, the control logic raises a flush request at some point in the cycle. The sequencer then marks the whole of the next instruction cycle as a forced no-operation. The prefetched instruction is dropped and that cycle performs no write.

A sleep request finishes the current cycle through Q4 and then stops all strobes. A wake request restarts the sequence at Q1. Hardware-owned flag bits can use the Q1 strobe as their update slot, so that a read-modify-write that spans Q2 to Q4 never loses them.

Top module: `quad_phase_seq`

## Requirements
- R1: After a clock edge with `rst_n` low, the sequencer is running, `phase_o` is 4'b0001 (Q1), and `fnop_o` is 1, so the first cycle after reset is a forced no-operation.
- R2: While running, `phase_o` is one-hot and steps on every clock through bit 0 (Q1), bit 1 (Q2), bit 2 (Q3) and bit 3 (Q4), then returns to bit 0.
- R3: `cyc_en_o` is 1 exactly in the clocks where the sequencer is running and `phase_o` is bit 3 (Q4); otherwise it is 0.
- R4: If `flush_req` is high at any clock edge of a running cycle, including its Q4 edge, `fnop_o` is 1 for all four phases of the next cycle. With no flush request, `fnop_o` is 0 for the next cycle. `fnop_o` changes only at a cycle boundary.
- R5: `wr_en_o` is 1 only in Q4 of a cycle whose `fnop_o` is 0.
- R6: Several flush requests inside one cycle yield exactly one forced no-operation cycle.
- R7: A `sleep_req` seen at any edge of a running cycle lets that cycle finish its Q4. After that, `phase_o`, `cyc_en_o` and `wr_en_o` stay 0.
- R8: `wake_req` while stopped starts Q1 at the next clock. `fnop_o` keeps the value that was decided at the boundary where the sequencer stopped.
- R9: `wake_req` while running has no effect. `sleep_req` and `flush_req` while stopped have no effect on the sequence or on `fnop_o`.
- R10: Reset in the middle of a cycle abandons it and returns to the state of R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_req | input | 1 | Stop phase generation after the current Q4 |
| wake_req | input | 1 | Restart phase generation at Q1 when stopped |
| flush_req | input | 1 | Turn the next cycle into a forced no-operation |
| phase_o | output | 4 | One-hot phase strobes, bit 0 = Q1 … bit 3 = Q4 |
| cyc_en_o | output | 1 | Instruction-cycle enable, high during Q4 |
| fnop_o | output | 1 | Current cycle is a forced no-operation |
| wr_en_o | output | 1 | Write-phase strobe, Q4 of a non-flushed cycle |

## Verification
The bench places flush requests in every phase, including on the Q4 edge itself. A design that sampled the request only at one phase, or that cleared a pending request one edge too early, would then miss a no-operation cycle or make one too many. The bench raises several flushes in a single cycle, which catches a design that counts requests instead of flagging the next cycle. It also asserts sleep in the middle of a cycle, which exposes a sequencer that halts before Q4 or keeps emitting strobes afterwards. Finally, it presents wake while running and flush or sleep while stopped, which exposes controllers that react to requests outside their valid state.

// File: rtl/qseq_pkg.sv
// Package: shared types for the four-phase cycle sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package qseq_pkg;

    // Ring status shared by the run and no-operation controllers.
    typedef struct packed {
        logic run;   // phase generation active
        logic last;  // current clock is the final phase of a running cycle
    } ring_status_t;

endpackage

// File: rtl/qseq_ring.sv
// Module: phase ring. Counts oscillator clocks inside one instruction cycle
// and decodes one strobe per phase.
// Assumes: run only falls on the clock after the final phase (or by reset),
// and the count parks at the first phase while run is low.
module qseq_ring #(
    parameter int unsigned PHASES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    output logic [PHASES-1:0] strobe_o,
    output logic              last_o
);
    localparam int unsigned IDX_W = (PHASES > 1) ? $clog2(PHASES) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PHASES - 1);

    logic [IDX_W-1:0] idx_q;

    // Advance the phase index while running, park it at the first phase otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)                idx_q <= '0;
        else if (!run)             idx_q <= '0;
        else if (idx_q == LAST_IDX) idx_q <= '0;
        else                       idx_q <= idx_q + 1'b1;
    end

    // Decode one strobe per phase.
    for (genvar g = 0; g < PHASES; g++) begin : g_strobe
        assign strobe_o[g] = run && (idx_q == IDX_W'(g));
    end

    assign last_o = run && (idx_q == LAST_IDX);

    // R2: at most one strobe active at any time
    p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(strobe_o));

    // R2: inside a cycle, the strobe moves up by exactly one phase
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !last_o) |=> (strobe_o == ($past(strobe_o) << 1)));
endmodule

// File: rtl/qseq_run_ctrl.sv
// Module: run controller. Holds the running flag, latches a sleep request
// until the cycle boundary and restarts on wake.
// Assumes: status.last is only high while status.run is high.
module qseq_run_ctrl
    import qseq_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sleep_req,
    input  logic         wake_req,
    input  ring_status_t status,
    output logic         run_o
);
    logic sleep_pend_q;

    // Remember a sleep request made during a running cycle until its last phase.
    always_ff @(posedge clk) begin
        if (!rst_n)              sleep_pend_q <= 1'b0;
        else if (status.last)    sleep_pend_q <= 1'b0;
        else if (status.run && sleep_req) sleep_pend_q <= 1'b1;
    end

    // Stop at a boundary with sleep pending; restart on wake while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   run_o <= 1'b1;
        else if (status.last && (sleep_pend_q || sleep_req)) run_o <= 1'b0;
        else if (!run_o && wake_req)                  run_o <= 1'b1;
    end

    // R7: running never stops in the middle of a cycle
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run_o && !status.last) |=> run_o);

    // R8: wake while stopped restarts at the next edge
    p_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_o && wake_req) |=> run_o);
endmodule

// File: rtl/qseq_nop_ctrl.sv
// Module: forced no-operation controller. Collects flush requests over a
// running cycle and marks the following cycle as a dummy cycle.
// Assumes: status.last marks the final phase; requests while stopped are dropped.
module qseq_nop_ctrl
    import qseq_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush_req,
    input  ring_status_t status,
    output logic         fnop_o
);
    logic flush_pend_q;

    // Collapse any number of flush requests in a cycle into one pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n)                       flush_pend_q <= 1'b0;
        else if (status.last)             flush_pend_q <= 1'b0;
        else if (status.run && flush_req) flush_pend_q <= 1'b1;
    end

    // Decide the no-operation state of the next cycle at the boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)           fnop_o <= 1'b1;
        else if (status.last) fnop_o <= flush_pend_q || flush_req;
    end

    // R4: the flag is constant across the phases of one cycle
    p_fnop_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !status.last |=> $stable(fnop_o));

    // R4: a flush on the boundary edge always yields a dummy cycle
    p_flush_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (status.last && flush_req) |=> fnop_o);
endmodule

// File: rtl/quad_phase_seq.sv
// Module: four-phase instruction cycle sequencer (top). Ties the phase ring,
// run controller and no-operation controller together and derives the
// cycle enable and the write strobe.
// Assumes: requests are synchronous to clk; reset is synchronous, active low.
module quad_phase_seq
    import qseq_pkg::*;
#(
    parameter int unsigned PHASES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep_req,
    input  logic              wake_req,
    input  logic              flush_req,
    output logic [PHASES-1:0] phase_o,
    output logic              cyc_en_o,
    output logic              fnop_o,
    output logic              wr_en_o
);
    logic         run;
    logic         last;
    ring_status_t status;

    assign status.run  = run;
    assign status.last = last;

    qseq_ring #(.PHASES(PHASES)) u_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .strobe_o (phase_o),
        .last_o   (last)
    );

    qseq_run_ctrl u_run (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep_req (sleep_req),
        .wake_req  (wake_req),
        .status    (status),
        .run_o     (run)
    );

    qseq_nop_ctrl u_nop (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush_req (flush_req),
        .status    (status),
        .fnop_o    (fnop_o)
    );

    // Cycle enable during the final phase; write only in a real cycle.
    assign cyc_en_o = last;
    assign wr_en_o  = last && !fnop_o;

    // R3: the cycle enable coincides with the final phase strobe
    p_cyc_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_en_o |-> phase_o[PHASES-1]);

    // R5: no write in a forced no-operation cycle
    p_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (!fnop_o && phase_o[PHASES-1]));

    // R7: nothing strobes while stopped
    p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (phase_o == '0 && !cyc_en_o && !wr_en_o));

    // R8: a restart begins at the first phase
    p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && wake_req) |=> phase_o[0]);
endmodule

// File: tb/tb_quad_phase_seq.sv
module tb_quad_phase_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sleep_req = 1'b0, wake_req = 1'b0, flush_req = 1'b0;
    logic [3:0] phase_o;
    logic       cyc_en_o, fnop_o, wr_en_o;

    int    n_checks = 0;
    int    n_errors = 0;
    string cur_req = "R1";

    // behavioural model state
    bit m_run = 1'b1;
    int m_ph = 0;
    bit m_fnop = 1'b1;
    bit m_fpend = 1'b0;
    bit m_spend = 1'b0;

    always #2 clk = ~clk;

    quad_phase_seq dut (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake_req(wake_req),
        .flush_req(flush_req), .phase_o(phase_o), .cyc_en_o(cyc_en_o),
        .fnop_o(fnop_o), .wr_en_o(wr_en_o)
    );

    task automatic model_edge();
        if (!rst_n) begin
            m_run = 1; m_ph = 0; m_fnop = 1; m_fpend = 0; m_spend = 0;
        end else if (m_run) begin
            if (m_ph == 3) begin
                m_fnop = m_fpend || flush_req;
                if (m_spend || sleep_req) m_run = 0;
                m_fpend = 0; m_spend = 0; m_ph = 0;
            end else begin
                m_ph++;
                if (flush_req) m_fpend = 1;
                if (sleep_req) m_spend = 1;
            end
        end else if (wake_req) begin
            m_run = 1; m_ph = 0;
        end
    endtask

    task automatic compare();
        logic [3:0] e_ph;
        logic e_cyc, e_wr;
        e_ph  = m_run ? 4'(1 << m_ph) : 4'b0;
        e_cyc = m_run && (m_ph == 3);
        e_wr  = e_cyc && !m_fnop;
        n_checks++;
        if (phase_o !== e_ph || cyc_en_o !== e_cyc || fnop_o !== m_fnop || wr_en_o !== e_wr) begin
            n_errors++;
            $display("FAIL %s: phase=%b cyc=%b fnop=%b wr=%b expected phase=%b cyc=%b fnop=%b wr=%b",
                     cur_req, phase_o, cyc_en_o, fnop_o, wr_en_o, e_ph, e_cyc, m_fnop, e_wr);
        end
    endtask

    // Drive inputs at the falling edge, advance through one rising edge, compare.
    task automatic tick(input bit s, input bit w, input bit f);
        sleep_req = s; wake_req = w; flush_req = f;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(0, 0, 0);
    endtask

    task automatic to_phase(input int p);
        while (!(m_run && m_ph == p)) tick(0, 0, 0);
    endtask

    initial begin
        #(4 * 100000);
        n_errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        cur_req = "R1"; rst_n = 0;
        tick(0, 0, 0); tick(0, 0, 0);
        rst_n = 1;
        cur_req = "R2"; idle(12);                  // R2 R3 R5 sequence after reset
        cur_req = "R4"; to_phase(1); tick(0, 0, 1); idle(8);   // flush in Q2
        cur_req = "R4"; to_phase(3); tick(0, 0, 1); idle(8);   // flush on Q4 edge
        cur_req = "R6"; to_phase(0); tick(0, 0, 1); tick(0, 0, 1); tick(0, 0, 0); tick(0, 0, 1); idle(8);
        cur_req = "R9"; to_phase(2); tick(0, 1, 0); tick(0, 1, 0); idle(6);  // wake while running
        cur_req = "R7"; to_phase(1); tick(1, 0, 0); idle(8);   // sleep mid cycle
        cur_req = "R9"; tick(1, 0, 1); tick(0, 0, 1); tick(1, 0, 0); idle(2);
        cur_req = "R8"; tick(0, 1, 0); idle(8);
        cur_req = "R8"; to_phase(2); tick(0, 0, 1); tick(1, 0, 0); idle(3);  // flushed then slept
        tick(0, 1, 0); idle(8);
        cur_req = "R10"; to_phase(2); rst_n = 0; tick(0, 0, 1); rst_n = 1; idle(6);
        cur_req = "R2";
        begin
            int lfsr = 32'h1ACE;
            for (int i = 0; i < 400; i++) begin
                lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
                tick((lfsr & 32'h1F) == 3, (lfsr & 32'h7) == 5, (lfsr & 32'h30) == 32'h30);
            end
        end
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule